// File: doc/BRIEF.md
# Buffered Timer Counter with Command Field

A 16-bit timer/counter that advances once per prescaler tick. Software changes its control state through two aliases of one control byte: one alias sets every bit written as 1, the other clears every bit written as 1. Both aliases read back the same byte. Software never needs a read-modify-write to change a single control bit.

Three bits of the control byte are held state: count direction, one-shot mode and a lock on buffer updates. A three-bit command field in the upper bits is self-clearing. A nonzero command waits for the next tick and runs there. The commands restart the counter, halt it, force the period and compare buffers into the active registers, or copy the live count into a readable snapshot.

The period and compare values are double-buffered. Software writes the buffers. The active copies are refreshed on each wrap of the counter, unless the lock bit holds them. Input capture itself is not part of the block. The `cap_mode` input only tells the block that capture is active, and while it is high the lock bit is ignored.

Top module: `tcb_timer`

## Requirements
- R1: After reset, `count_o` is 0 and the counter is halted. Both control addresses read 0x00, the active period (addr 3) reads 0xFFFF, and the active compare (addr 6) reads 0.
- R2: A write to addr 5 sets each of control bits 0 (down), 1 (lock) and 2 (one-shot) whose written bit is 1. Bits written as 0 keep their value. The result reads back at both addr 4 and addr 5, in bits [2:0].
- R3: A write to addr 4 clears each control bit whose written bit is 1, and leaves the others unchanged. Bits [7:5] written to addr 4 have no effect.
- R4: A nonzero value in bits [7:5] of a write to addr 5 is held as the pending command and reads back in bits [7:5]. It runs on the next tick and then reads 0. Writing 0 to that field leaves the pending command and all other state unchanged.
- R5: Command 1 (restart) loads 0 when counting up, or the active period when counting down, on its tick. It then enables counting. The count does not step on that tick.
- R6: Command 2 (halt) stops counting on its tick without stepping. While halted, the count does not change.
- R7: While running, each tick adds 1 to the count when bit 0 is 0 and subtracts 1 when bit 0 is 1. Without a tick the count holds.
- R8: Counting up wraps from the active period to 0. Counting down wraps from 0 to the active period. `ovf_o` is high for exactly the one cycle after each wrap tick.
- R9: When one-shot is clear, counting goes on after a wrap. When one-shot is set, the counter wraps and then halts.
- R10: On a wrap, the period buffer (addr 1) and the compare buffer (addr 2) are copied into the active period (addr 3) and the active compare (addr 6), unless lock is set. Lock has no effect while `cap_mode` is 1.
- R11: Command 3 copies both buffers into the active registers on its tick, even with lock set. A running counter still steps on that tick.
- R12: Command 4 copies the count as it stood before that tick into the snapshot register (addr 0). A running counter still steps on that tick.
- R13: `match_o` is high while the counter is running and the count equals the active compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| tick | input | 1 | Prescaled count enable, one cycle per count |
| cap_mode | input | 1 | High while capture operation is active; overrides the lock |
| count_o | output | 16 | Live count value |
| ovf_o | output | 1 | One-cycle pulse after a wrap in either direction |
| match_o | output | 1 | Running count equals the active compare |

## Verification
The bound checker checks the per-cycle rules on every clock. A pending command is gone after its tick. `ovf_o` only follows a tick. A halted count stays still. An up-count step adds exactly one. A restart leaves the counter running. A locked period does not move unless capture is active or an update is forced. The values themselves need the bench's reference model and its scenarios. These cover the wrap value in each direction, whether a given wrap copies the buffers, what the snapshot captures, and that a one-shot run stays halted at 0.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_RESTART   = 3'd1,
        CMD_HALT      = 3'd2,
        CMD_FORCE_UPD = 3'd3,
        CMD_SNAP      = 3'd4
    } cmd_e;

    typedef struct packed {
        logic oneshot;
        logic lock;
        logic down;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] cmd;
        logic [1:0] rsvd;
        ctrl_t      bits;
    } ctrl_byte_t;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_SNAP = 4'd0;
    localparam logic [ADDR_W-1:0] A_PBUF = 4'd1;
    localparam logic [ADDR_W-1:0] A_CBUF = 4'd2;
    localparam logic [ADDR_W-1:0] A_PER  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd4;
    localparam logic [ADDR_W-1:0] A_SET  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CMP  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd7;

    function automatic ctrl_byte_t pack_ctrl(cmd_e pend, ctrl_t c);
        ctrl_byte_t b;
        b.cmd  = pend;
        b.rsvd = 2'b00;
        b.bits = c;
        return b;
    endfunction

endpackage

// File: rtl/tcb_ctrl_regs.sv
module tcb_ctrl_regs
    import tcb_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter logic [CW-1:0] PER_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    input  logic              cmd_done,
    output ctrl_t             ctrl,
    output cmd_e              pend,
    output logic [CW-1:0]     pbuf,
    output logic [CW-1:0]     cbuf
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    ctrl_byte_t wr_byte;
    assign wr_byte = ctrl_byte_t'(wdata[7:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            pend <= CMD_NONE;
            pbuf <= PER_RST;
            cbuf <= '0;
        end else begin
            if (cmd_done) pend <= CMD_NONE;
            if (we) begin
                case (addr)
                    A_SET: begin
                        ctrl <= ctrl_t'(CTRL_W'(ctrl) | CTRL_W'(wr_byte.bits));
                        if (wr_byte.cmd != 3'd0) pend <= cmd_e'(wr_byte.cmd);
                    end
                    A_CLR:  ctrl <= ctrl_t'(CTRL_W'(ctrl) & ~CTRL_W'(wr_byte.bits));
                    A_PBUF: pbuf <= wdata;
                    A_CBUF: cbuf <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tcb_count_core.sv
module tcb_count_core
    import tcb_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  cmd_e          pend,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] count,
    output logic          run,
    output logic          wrap,
    output logic          cmd_done,
    output logic          force_upd,
    output logic [CW-1:0] snap,
    output logic          ovf_q
);
    logic          do_restart;
    logic          do_halt;
    logic          do_snap;
    logic          step_en;
    logic          at_end;
    logic [CW-1:0] wrap_val;
    logic [CW-1:0] nxt;

    always_comb begin
        cmd_done   = tick && (pend != CMD_NONE);
        do_restart = tick && (pend == CMD_RESTART);
        do_halt    = tick && (pend == CMD_HALT);
        do_snap    = tick && (pend == CMD_SNAP);
        force_upd  = tick && (pend == CMD_FORCE_UPD);
        step_en    = tick && run && !do_restart && !do_halt;
        at_end     = ctrl.down ? (count == '0) : (count == per);
        wrap_val   = ctrl.down ? per : '0;
        wrap       = step_en && at_end;
        if (at_end)          nxt = wrap_val;
        else if (ctrl.down)  nxt = count - 1'b1;
        else                 nxt = count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
            snap  <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (do_restart) begin
                count <= wrap_val;
                run   <= 1'b1;
            end else begin
                if (do_halt) run <= 1'b0;
                if (do_snap) snap <= count;
                if (step_en) begin
                    count <= nxt;
                    if (wrap && ctrl.oneshot) run <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tcb_dbuf.sv
module tcb_dbuf #(
    parameter int unsigned CW      = 16,
    parameter logic [CW-1:0] PER_RST = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap,
    input  logic          force_upd,
    input  logic          lock,
    input  logic          cap_mode,
    input  logic [CW-1:0] pbuf,
    input  logic [CW-1:0] cbuf,
    output logic [CW-1:0] per,
    output logic [CW-1:0] cmp
);
    logic upd;
    assign upd = force_upd || (wrap && (!lock || cap_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            per <= PER_RST;
            cmp <= '0;
        end else if (upd) begin
            per <= pbuf;
            cmp <= cbuf;
        end
    end
endmodule

// File: rtl/tcb_timer.sv
module tcb_timer
    import tcb_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CW-1:0]     reg_wdata,
    output logic [CW-1:0]     reg_rdata,
    input  logic              tick,
    input  logic              cap_mode,
    output logic [CW-1:0]     count_o,
    output logic              ovf_o,
    output logic              match_o
);
    localparam logic [CW-1:0] PER_RST = '1;

    ctrl_t         ctrl;
    cmd_e          pend_cmd;
    logic [CW-1:0] pbuf, cbuf, per, cmp, count, snap;
    logic          run, wrap, cmd_done, force_upd, ovf_q;

    tcb_ctrl_regs #(.CW(CW), .PER_RST(PER_RST)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cmd_done(cmd_done), .ctrl(ctrl), .pend(pend_cmd), .pbuf(pbuf), .cbuf(cbuf)
    );

    tcb_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .pend(pend_cmd), .ctrl(ctrl), .per(per),
        .count(count), .run(run), .wrap(wrap), .cmd_done(cmd_done),
        .force_upd(force_upd), .snap(snap), .ovf_q(ovf_q)
    );

    tcb_dbuf #(.CW(CW), .PER_RST(PER_RST)) u_dbuf (
        .clk(clk), .rst(rst), .wrap(wrap), .force_upd(force_upd), .lock(ctrl.lock),
        .cap_mode(cap_mode), .pbuf(pbuf), .cbuf(cbuf), .per(per), .cmp(cmp)
    );

    always_comb begin
        case (reg_addr)
            A_SNAP:       reg_rdata = snap;
            A_PBUF:       reg_rdata = pbuf;
            A_CBUF:       reg_rdata = cbuf;
            A_PER:        reg_rdata = per;
            A_CLR, A_SET: reg_rdata = CW'(pack_ctrl(pend_cmd, ctrl));
            A_CMP:        reg_rdata = cmp;
            A_CNT:        reg_rdata = count;
            default:      reg_rdata = '0;
        endcase
    end

    assign count_o = count;
    assign ovf_o   = ovf_q;
    assign match_o = run && (count == cmp);
endmodule

// File: rtl/tcb_timer_chk.sv
module tcb_timer_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          we,
    input logic [3:0]    addr,
    input logic          cap_mode,
    input logic [2:0]    pend,
    input logic          run,
    input logic          down,
    input logic          lock,
    input logic [CW-1:0] count,
    input logic [CW-1:0] per,
    input logic          ovf
);
    // R4
    pend_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pend != 3'd0 && !(we && addr == 4'd5)) |=> (pend == 3'd0));

    // R8
    ovf_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(tick));

    // R6
    halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !(tick && pend == 3'd1)) |=> $stable(count));

    // R7
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run && pend == 3'd0 && !down && count != per)
        |=> (count == CW'($past(count) + 1'b1)));

    // R5
    restart_runs_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pend == 3'd1) |=> run);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !cap_mode && !(tick && pend == 3'd3)) |=> $stable(per));
endmodule

bind tcb_timer tcb_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .we(reg_we), .addr(reg_addr),
    .cap_mode(cap_mode), .pend(pend_cmd), .run(run), .down(ctrl.down),
    .lock(ctrl.lock), .count(count), .per(per), .ovf(ovf_q)
);

// File: tb/tcb_timer_bench.sv
`timescale 1ns/1ps
module tcb_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic        tick = 1'b0;
    logic        cap_mode = 1'b0;
    logic [15:0] rdata, count_o;
    logic        ovf_o, match_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tcb_timer u_tcb_timer (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .tick(tick), .cap_mode(cap_mode),
        .count_o(count_o), .ovf_o(ovf_o), .match_o(match_o)
    );

    // behavioural reference state
    logic [15:0] m_cnt, m_per, m_cmp, m_pbuf, m_cbuf, m_snap;
    logic [2:0]  m_ctrl, m_pend;
    logic        m_run, m_ovf;
    logic [15:0] t_cnt, t_per, t_cmp, t_pbuf, t_cbuf, t_snap;
    logic [2:0]  t_ctrl, t_pend;
    logic        t_run, t_ovf;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] mrd(input logic [3:0] a);
        case (a)
            4'd0: return m_snap;
            4'd1: return m_pbuf;
            4'd2: return m_cbuf;
            4'd3: return m_per;
            4'd4, 4'd5: return {8'd0, m_pend, 2'b00, m_ctrl};
            4'd6: return m_cmp;
            4'd7: return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 16'hFFFF; m_cmp = 0; m_pbuf = 16'hFFFF; m_cbuf = 0;
            m_snap = 0; m_ctrl = 0; m_pend = 0; m_run = 0; m_ovf = 0;
        end else begin
            t_cnt = m_cnt; t_per = m_per; t_cmp = m_cmp; t_pbuf = m_pbuf; t_cbuf = m_cbuf;
            t_snap = m_snap; t_ctrl = m_ctrl; t_pend = m_pend; t_run = m_run; t_ovf = 0;
            if (tick) begin
                if (m_pend == 3'd1) begin
                    t_cnt = m_ctrl[0] ? m_per : 16'd0;
                    t_run = 1;
                end else begin
                    if (m_pend == 3'd4) t_snap = m_cnt;
                    if (m_pend == 3'd3) begin t_per = m_pbuf; t_cmp = m_cbuf; end
                    if (m_pend == 3'd2) t_run = 0;
                    else if (m_run) begin
                        if (!m_ctrl[0]) begin
                            if (m_cnt == m_per) begin t_cnt = 0; t_ovf = 1; end
                            else t_cnt = m_cnt + 1;
                        end else begin
                            if (m_cnt == 0) begin t_cnt = m_per; t_ovf = 1; end
                            else t_cnt = m_cnt - 1;
                        end
                        if (t_ovf) begin
                            if (!m_ctrl[1] || cap_mode) begin t_per = m_pbuf; t_cmp = m_cbuf; end
                            if (m_ctrl[2]) t_run = 0;
                        end
                    end
                end
                t_pend = 0;
            end
            if (we) begin
                case (addr)
                    4'd5: begin
                        t_ctrl = m_ctrl | wdata[2:0];
                        if (wdata[7:5] != 0) t_pend = wdata[7:5];
                    end
                    4'd4: t_ctrl = m_ctrl & ~wdata[2:0];
                    4'd1: t_pbuf = wdata;
                    4'd2: t_cbuf = wdata;
                    default: ;
                endcase
            end
            m_cnt = t_cnt; m_per = t_per; m_cmp = t_cmp; m_pbuf = t_pbuf; m_cbuf = t_cbuf;
            m_snap = t_snap; m_ctrl = t_ctrl; m_pend = t_pend; m_run = t_run; m_ovf = t_ovf;
        end
    end

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk("R7 count", count_o, m_cnt);
            chk("R8 ovf", ovf_o, m_ovf);
            chk("R13 match", match_o, m_run && (m_cnt == m_cmp));
            chk("R2 rdata", rdata, mrd(addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0; wdata = 0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
        end
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 count", count_o, 16'd0);
        rdchk(4'd5, 16'h0000, "R1 set alias");
        rdchk(4'd4, 16'h0000, "R1 clr alias");
        rdchk(4'd3, 16'hFFFF, "R1 period");
        rdchk(4'd6, 16'h0000, "R1 compare");
        // R2 set alias, visible at both
        wr(4'd5, 16'h0007);
        rdchk(4'd4, 16'h0007, "R2 via clr alias");
        rdchk(4'd5, 16'h0007, "R2 via set alias");
        // R3 clear alias
        wr(4'd4, 16'h0002);
        rdchk(4'd5, 16'h0005, "R3 lock cleared");
        wr(4'd4, 16'h00E0);
        rdchk(4'd5, 16'h0005, "R3 cmd bits ignored");
        wr(4'd4, 16'h0005);
        rdchk(4'd4, 16'h0000, "R3 all cleared");
        // R4 / R11 force update
        wr(4'd1, 16'd5);
        wr(4'd2, 16'd3);
        wr(4'd5, 16'h0060);
        rdchk(4'd5, 16'h0060, "R4 pending visible");
        tk(1);
        rdchk(4'd5, 16'h0000, "R4 self cleared");
        rdchk(4'd3, 16'd5, "R11 period copied");
        rdchk(4'd6, 16'd3, "R11 compare copied");
        // R5 restart counting up
        wr(4'd5, 16'h0020);
        tk(1);
        chk("R5 restart up", count_o, 16'd0);
        tk(3);
        chk("R7 up by three", count_o, 16'd3);
        chk("R13 match at compare", match_o, 1'b1);
        tk(2);
        tk(1);
        chk("R8 up wrap to 0", count_o, 16'd0);
        chk("R8 ovf pulse", ovf_o, 1'b1);
        @(negedge clk);
        chk("R8 ovf one cycle", ovf_o, 1'b0);
        // R9 continuing (one-shot clear)
        tk(1);
        chk("R9 continues", count_o, 16'd1);
        tk(1);
        chk("R7 up", count_o, 16'd2);
        // down
        wr(4'd5, 16'h0001);
        tk(2);
        chk("R8 down to 0", count_o, 16'd0);
        tk(1);
        chk("R8 down wrap to period", count_o, 16'd5);
        tk(2);
        chk("R7 down", count_o, 16'd3);
        // R10 lock
        wr(4'd5, 16'h0002);
        wr(4'd1, 16'd9);
        tk(4);
        chk("R8 locked wrap", count_o, 16'd5);
        rdchk(4'd3, 16'd5, "R10 lock holds period");
        cap_mode = 1;
        tk(6);
        cap_mode = 0;
        rdchk(4'd3, 16'd9, "R10 lock ignored in capture");
        chk("R8 wrap uses old period", count_o, 16'd5);
        // R11 force update while locked
        wr(4'd1, 16'd7);
        wr(4'd5, 16'h0060);
        tk(1);
        rdchk(4'd3, 16'd7, "R11 forced through lock");
        chk("R11 still steps", count_o, 16'd4);
        // R12 read sync
        wr(4'd5, 16'h0080);
        tk(1);
        rdchk(4'd0, 16'd4, "R12 snapshot");
        chk("R12 still steps", count_o, 16'd3);
        // R6 halt
        wr(4'd5, 16'h0040);
        tk(1);
        chk("R6 halt no step", count_o, 16'd3);
        tk(3);
        chk("R6 halted holds", count_o, 16'd3);
        chk("R13 no match when halted", match_o, 1'b0);
        // R9 one-shot
        wr(4'd4, 16'h0003);
        wr(4'd5, 16'h0004);
        wr(4'd5, 16'h0000);
        rdchk(4'd5, 16'h0004, "R4 zero command no effect");
        wr(4'd5, 16'h0020);
        tk(1);
        chk("R5 restart", count_o, 16'd0);
        tk(7);
        chk("R7 up to period", count_o, 16'd7);
        tk(1);
        chk("R9 wrapped", count_o, 16'd0);
        chk("R8 one-shot ovf", ovf_o, 1'b1);
        tk(2);
        chk("R9 one-shot stopped", count_o, 16'd0);
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule